// File: doc/BRIEF.md
# Mixed-Access Control and Status Register Bank

This block is the register file that a processor reaches over a small parallel bus: an 8-bit data path, a 4-bit address, and separate one-cycle read and write strobes. Behind that bus sit a few fields, and each field has its own access behaviour. There are plain configuration bytes. There is a live version input that software cannot change. There is an error flag that holds until software writes a 1 to it, and a second flag that clears when software reads it. There is a 16-bit event counter that saturates, a byte of one-cycle command pulses, and a write-only setting.

All read data passes through one registered multiplexer. The byte software asks for therefore appears one clock after the read strobe and holds there until the next read. The counter is wider than the bus, so it occupies two consecutive addresses. Reading the low byte also freezes the high byte, so the two halves software sees belong to the same moment. All flops reset asynchronously on an active-low reset. Their reset values are parameters and default to zero.

Address map (the address is `addr`; a bit index counts from the least significant bit of the data bus):

| Address | Bits | Field |
|---|---|---|
| 0 | 7:0 | `cfgA`, read/write |
| 1 | 7:0 | `versionIn`, read-only |
| 2 | 3:0 | `cfgB`, read/write |
| 2 | 6 | error flag: set by `errEvt`, cleared by writing 1 |
| 3 | 0 | event flag: set by `corEvt`, cleared by a read |
| 4 | 7:0 | counter bits 7:0 |
| 5 | 7:0 | counter bits 15:8, as captured at the last read of address 4 |
| 6 | 7:0 | `cmdPulse`, write-only one-cycle pulses |
| 7 | 7:0 | `wrOnlyVal`, write-only |

Top module: `ctrlStatBank`

## Requirements
- R1: A write changes only the field bits mapped at its address. Address 0 holds an 8-bit read/write field, driven on `cfgA`. Address 2 bits 3:0 hold a 4-bit read/write field, driven on `cfgB`. Every other field keeps its value.
- R2: Read data is registered. `rdData` takes the addressed value at the clock edge where `rdStb` is high, and it holds that value through every cycle without a read.
- R3: A read of address 1 returns the value `versionIn` had at the read edge. Writes to address 1 have no effect.
- R4: The error flag sets when `errEvt` is high at a clock edge and then stays set. A write to address 2 with bit 6 at 1 clears it. A write with bit 6 at 0 leaves it set.
- R5: When `errEvt` is high in the same cycle as a clearing write to address 2, the error flag ends up set.
- R6: The event flag sets when `corEvt` is high. A read of address 3 returns the flag's value from before the read and clears the flag, unless `corEvt` is high in that same cycle.
- R7: The 16-bit counter adds one at each clock edge where `cntEvt` is high, and it stops at 0xFFFF.
- R8: A read of address 4 returns counter bits 7:0 and copies counter bits 15:8 into a capture register. It also clears the counter, which becomes 1 if `cntEvt` is high at that edge. A read of address 5 returns the capture register.
- R9: A write to address 6 drives the written byte on `cmdPulse` for exactly one cycle, starting at the write edge. `cmdPulse` is zero at all other times. A read of address 6 returns zero.
- R10: A write to address 7 sets `wrOnlyVal`. A read of address 7 returns zero.
- R11: Addresses 8 to 15, and the unmapped bits at addresses 2 and 3, read as zero. Writes to addresses 8 to 15 change no field.
- R12: While `rstN` is low, every field, `cmdPulse` and `rdData` are zero with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdStb | input | 1 | Single-cycle read strobe |
| wrStb | input | 1 | Single-cycle write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| versionIn | input | 8 | Live version value, read-only at address 1 |
| errEvt | input | 1 | Hardware event that sets the error flag |
| corEvt | input | 1 | Hardware event that sets the clear-on-read flag |
| cntEvt | input | 1 | Counter increment event |
| cfgA | output | 8 | Read/write field at address 0 |
| cfgB | output | 4 | Read/write field at address 2, bits 3:0 |
| cmdPulse | output | 8 | One-cycle pulses from writes to address 6 |
| wrOnlyVal | output | 8 | Write-only field at address 7 |

## Verification
The bench deliberately makes a hardware event and a bus clear land on the same clock edge, in three places. It holds `errEvt` high through a write of 1 to bit 6 of address 2, and the flag must read back as set. It holds `corEvt` high through a read of address 3: the read must return the old value and a second read must still see the flag set. It holds `cntEvt` high through a read of address 4, and the next read must return exactly 1, because the clear is applied first and the event is then counted. The bench decides these outcomes from the priority rules in R5, R6 and R8, and queues the expected bytes before issuing the reads.

// File: rtl/ctrlStatPkg.sv
package ctrlStatPkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int NUM_ADDR = 1 << ADDR_W;

  // Address map
  localparam int A_CFG    = 0;
  localparam int A_VER    = 1;
  localparam int A_MIX    = 2;
  localparam int A_COR    = 3;
  localparam int A_CNT_LO = 4;
  localparam int A_PULSE  = 6;
  localparam int A_WO     = 7;

  // Bit positions inside shared addresses
  localparam int MIX_CFG_W  = 4;
  localparam int MIX_ERR_BIT = 6;
  localparam int COR_BIT    = 0;

  // One-hot address hits produced by the control side
  typedef struct packed {
    logic [NUM_ADDR-1:0] wrHit;
    logic [NUM_ADDR-1:0] rdHit;
  } strobeT;
endpackage

// File: rtl/ctrlStatCtrl.sv
module ctrlStatCtrl
  import ctrlStatPkg::*;
(
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            stb
);
  // One comparator pair per address in the decode space
  for (genvar a = 0; a < NUM_ADDR; a++) begin : gDecode
    assign stb.wrHit[a] = wrStb && (addr == ADDR_W'(a));
    assign stb.rdHit[a] = rdStb && (addr == ADDR_W'(a));
  end
endmodule

// File: rtl/ctrlStatData.sv
module ctrlStatData
  import ctrlStatPkg::*;
#(
  parameter int                CNT_W    = 16,
  parameter logic [DATA_W-1:0] CFGA_RST = '0,
  parameter logic [MIX_CFG_W-1:0] CFGB_RST = '0,
  parameter logic [DATA_W-1:0] WO_RST   = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] versionIn,
  input  logic              errEvt,
  input  logic              corEvt,
  input  logic              cntEvt,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cfgA,
  output logic [MIX_CFG_W-1:0] cfgB,
  output logic [DATA_W-1:0] cmdPulse,
  output logic [DATA_W-1:0] wrOnlyVal,
  output logic              errSticky,
  output logic              corSticky,
  output logic [CNT_W-1:0]  cntVal
);
  localparam int CNT_SLICES = CNT_W / DATA_W;
  localparam int SHADOW_W   = CNT_W - DATA_W;

  logic [SHADOW_W-1:0] cntShadow;
  logic [CNT_W-1:0]    cntNext;
  logic                errNext, corNext;
  logic [DATA_W-1:0]   rdNext;
  logic                unusedHits;

  // Plain read/write fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgA      <= CFGA_RST;
      cfgB      <= CFGB_RST;
      wrOnlyVal <= WO_RST;
    end else begin
      if (stb.wrHit[A_CFG]) cfgA      <= wrData;
      if (stb.wrHit[A_MIX]) cfgB      <= wrData[MIX_CFG_W-1:0];
      if (stb.wrHit[A_WO])  wrOnlyVal <= wrData;
    end
  end

  // Sticky flags: hardware event overrides the bus clear
  always_comb begin
    errNext = errSticky;
    if (stb.wrHit[A_MIX] && wrData[MIX_ERR_BIT]) errNext = 1'b0;
    if (errEvt) errNext = 1'b1;
    corNext = corSticky;
    if (stb.rdHit[A_COR]) corNext = 1'b0;
    if (corEvt) corNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errSticky <= 1'b0;
      corSticky <= 1'b0;
    end else begin
      errSticky <= errNext;
      corSticky <= corNext;
    end
  end

  // Saturating counter, cleared by a low-slice read, event applied after clear
  always_comb begin
    cntNext = cntVal;
    if (stb.rdHit[A_CNT_LO]) cntNext = '0;
    if (cntEvt && (cntNext != {CNT_W{1'b1}})) cntNext = cntNext + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal    <= '0;
      cntShadow <= '0;
    end else begin
      cntVal <= cntNext;
      if (stb.rdHit[A_CNT_LO]) cntShadow <= cntVal[CNT_W-1:DATA_W];
    end
  end

  // Pulse field: high for the single cycle after the write edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdPulse <= '0;
    else       cmdPulse <= stb.wrHit[A_PULSE] ? wrData : '0;
  end

  // Read multiplexer
  always_comb begin
    rdNext = '0;
    if (stb.rdHit[A_CFG]) rdNext = cfgA;
    if (stb.rdHit[A_VER]) rdNext = versionIn;
    if (stb.rdHit[A_MIX]) begin
      rdNext[MIX_CFG_W-1:0] = cfgB;
      rdNext[MIX_ERR_BIT]   = errSticky;
    end
    if (stb.rdHit[A_COR]) rdNext[COR_BIT] = corSticky;
    if (stb.rdHit[A_CNT_LO]) rdNext = cntVal[DATA_W-1:0];
    for (int s = 1; s < CNT_SLICES; s++) begin
      if (stb.rdHit[A_CNT_LO+s]) rdNext = cntShadow[(s-1)*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (|stb.rdHit)   rdData <= rdNext;
  end

  assign unusedHits = ^stb;
endmodule

// File: rtl/ctrlStatBank.sv
module ctrlStatBank
  import ctrlStatPkg::*;
#(
  parameter int CNT_W = 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdStb,
  input  logic                 wrStb,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [DATA_W-1:0]    versionIn,
  input  logic                 errEvt,
  input  logic                 corEvt,
  input  logic                 cntEvt,
  output logic [DATA_W-1:0]    cfgA,
  output logic [MIX_CFG_W-1:0] cfgB,
  output logic [DATA_W-1:0]    cmdPulse,
  output logic [DATA_W-1:0]    wrOnlyVal
);
  strobeT           stb;
  logic             errSticky;
  logic             corSticky;
  logic [CNT_W-1:0] cntVal;

  ctrlStatCtrl u_ctrl (
    .rdStb (rdStb),
    .wrStb (wrStb),
    .addr  (addr),
    .stb   (stb)
  );

  ctrlStatData #(.CNT_W(CNT_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .versionIn (versionIn),
    .errEvt    (errEvt),
    .corEvt    (corEvt),
    .cntEvt    (cntEvt),
    .rdData    (rdData),
    .cfgA      (cfgA),
    .cfgB      (cfgB),
    .cmdPulse  (cmdPulse),
    .wrOnlyVal (wrOnlyVal),
    .errSticky (errSticky),
    .corSticky (corSticky),
    .cntVal    (cntVal)
  );
endmodule

// File: rtl/ctrlStatChk.sv
module ctrlStatChk
  import ctrlStatPkg::*;
#(
  parameter int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStb,
  input logic              wrStb,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] versionIn,
  input logic              errEvt,
  input logic              corEvt,
  input logic [DATA_W-1:0] cmdPulse,
  input logic              errSticky,
  input logic              corSticky,
  input logic [CNT_W-1:0]  cntVal
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && !rdStb |=> $stable(rdData));

  // R3
  version_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && rdStb && addr == ADDR_W'(A_VER) |=> rdData == $past(versionIn));

  // R5
  err_evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && errEvt |=> errSticky);

  // R6
  cor_evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && corEvt |=> corSticky);

  // R7
  cnt_no_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && !(rdStb && addr == ADDR_W'(A_CNT_LO)) |=> cntVal >= $past(cntVal));

  // R9
  pulse_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && wrStb && addr == ADDR_W'(A_PULSE) |=> cmdPulse == $past(wrData));

  // R9
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && !(wrStb && addr == ADDR_W'(A_PULSE)) |=> cmdPulse == '0);

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && rdStb && addr[ADDR_W-1] |=> rdData == '0);
endmodule

bind ctrlStatBank ctrlStatChk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/ctrlStatBank_bench.sv
`timescale 1ns/1ps
module ctrlStatBank_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdStb = 1'b0, wrStb = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0, versionIn = '0;
  logic       errEvt = 1'b0, corEvt = 1'b0, cntEvt = 1'b0;
  logic [7:0] rdData, cfgA, cmdPulse, wrOnlyVal;
  logic [3:0] cfgB;

  int nChecks = 0, nFails = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  ctrlStatBank u_ctrlStatBank (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb), .addr(addr),
    .wrData(wrData), .rdData(rdData), .versionIn(versionIn), .errEvt(errEvt),
    .corEvt(corEvt), .cntEvt(cntEvt), .cfgA(cfgA), .cfgB(cfgB),
    .cmdPulse(cmdPulse), .wrOnlyVal(wrOnlyVal)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver tasks are called at a falling edge and return at the next one
  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    wrStb = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    rdStb = 1'b1; addr = a;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  // Monitor: compare registered read data 1 ns after each read edge
  initial forever begin
    @(posedge clk);
    if (rdStb === 1'b1) begin
      #1;
      if (expQ.size() == 0) chk("queue", 8'hxx, 8'h00);
      else chk(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1000000;
    chk("watchdog", 8'h01, 8'h00);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 rdData", rdData, 8'h00);
    chk("R12 cfgA", cfgA, 8'h00);
    chk("R12 cmdPulse", cmdPulse, 8'h00);
    chk("R12 wrOnlyVal", wrOnlyVal, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    doRead(4'd0, 8'h00, "R12 addr0");
    doRead(4'd2, 8'h00, "R12 addr2");

    // R1 read/write fields
    doWrite(4'd0, 8'hA5);
    doRead(4'd0, 8'hA5, "R1 addr0");
    doWrite(4'd2, 8'h0F);
    doRead(4'd2, 8'h0F, "R1 addr2");
    doRead(4'd0, 8'hA5, "R1 addr0 kept");
    chk("R1 cfgB", {4'h0, cfgB}, 8'h0F);

    // R2 hold without read
    doWrite(4'd0, 8'h11);
    repeat (2) @(negedge clk);
    chk("R2 hold", rdData, 8'hA5);
    doRead(4'd0, 8'h11, "R2 new read");

    // R3 read-only version
    versionIn = 8'h3C;
    doRead(4'd1, 8'h3C, "R3 version");
    doWrite(4'd1, 8'hFF);
    doRead(4'd1, 8'h3C, "R3 write ignored");
    versionIn = 8'h5A;
    doRead(4'd1, 8'h5A, "R3 live");

    // R4 write-1-to-clear flag
    errEvt = 1'b1; @(negedge clk); errEvt = 1'b0;
    doRead(4'd2, 8'h4F, "R4 set");
    doRead(4'd2, 8'h4F, "R4 stays");
    doWrite(4'd2, 8'h0F);
    doRead(4'd2, 8'h4F, "R4 write 0 keeps");
    doWrite(4'd2, 8'h4F);
    doRead(4'd2, 8'h0F, "R4 cleared");

    // R5 event beats clear
    errEvt = 1'b1; doWrite(4'd2, 8'h40); errEvt = 1'b0;
    doRead(4'd2, 8'h40, "R5 event wins");
    doWrite(4'd2, 8'h40);
    doRead(4'd2, 8'h00, "R5 later clear");

    // R6 clear-on-read flag
    corEvt = 1'b1; @(negedge clk); corEvt = 1'b0;
    doRead(4'd3, 8'h01, "R6 pre-clear value");
    doRead(4'd3, 8'h00, "R6 cleared");
    corEvt = 1'b1; @(negedge clk);
    doRead(4'd3, 8'h01, "R6 read with event");
    corEvt = 1'b0;
    doRead(4'd3, 8'h01, "R6 event kept");
    doRead(4'd3, 8'h00, "R6 cleared again");

    // R7 / R8 counter
    doRead(4'd4, 8'h00, "R8 initial");
    cntEvt = 1'b1; repeat (5) @(negedge clk); cntEvt = 1'b0;
    doRead(4'd4, 8'h05, "R7 count 5");
    doRead(4'd5, 8'h00, "R8 high 0");
    cntEvt = 1'b1; repeat (300) @(negedge clk); cntEvt = 1'b0;
    doRead(4'd4, 8'h2C, "R7 count 300 low");
    doRead(4'd5, 8'h01, "R8 captured high");
    doRead(4'd4, 8'h00, "R8 cleared");
    cntEvt = 1'b1;
    doRead(4'd4, 8'h00, "R8 read with event");
    cntEvt = 1'b0;
    doRead(4'd4, 8'h01, "R8 event after clear");
    cntEvt = 1'b1; repeat (70000) @(negedge clk); cntEvt = 1'b0;
    doRead(4'd4, 8'hFF, "R7 saturated low");
    doRead(4'd5, 8'hFF, "R7 saturated high");

    // R9 pulse field
    chk("R9 idle", cmdPulse, 8'h00);
    doWrite(4'd6, 8'h81);
    chk("R9 pulse", cmdPulse, 8'h81);
    @(negedge clk);
    chk("R9 one cycle", cmdPulse, 8'h00);
    doRead(4'd6, 8'h00, "R9 reads zero");

    // R10 write-only field
    doWrite(4'd7, 8'h3C);
    chk("R10 value", wrOnlyVal, 8'h3C);
    doRead(4'd7, 8'h00, "R10 reads zero");

    // R11 unmapped space
    doWrite(4'd9, 8'hFF);
    doRead(4'd9, 8'h00, "R11 addr9");
    doRead(4'd15, 8'h00, "R11 addr15");
    doRead(4'd0, 8'h11, "R11 addr0 untouched");
    chk("R11 wrOnlyVal", wrOnlyVal, 8'h3C);

    repeat (3) @(negedge clk);
    chk("queue drained", 8'(expQ.size()), 8'h00);
    finishRun();
  end
endmodule